// File: doc/BRIEF.md
# Thermal Throttle Clock Modulator

This block takes over once the die has been flagged as too hot. While the hot flag is set it holds a throttle-active status. When the hot flag drops, a hysteresis hold-off runs for a set number of time-base ticks before the status is released. If throttling is active and the frequency and voltage targets have already reached their floor, the block modulates the core clock enable. The duty cycle is fixed and is timed from a free-running one-microsecond tick, so the modulation period does not depend on the core clock frequency.

The block also stands in the path of performance-state requests. Frequencies are unsigned ratio codes, and a request is compared with the thermally optimized target `opt_freq_i`. While throttling is active, a request that would raise the frequency above that target is parked. A request at or below the target goes through at once. The parked request is passed on after the thermal event ends. Snoop and interrupt logic does not depend on this gate.

Top module: `thermal_clk_modulator`

## Requirements
- R1: A cycle with `hot_i` high sets `throttle_o` high on the next clock, and `throttle_o` stays high for as long as `hot_i` stays high.
- R2: After `hot_i` goes low, `throttle_o` stays high until HYST_TICKS ticks of `tick_i` have been counted with `hot_i` low, and it falls at the clock that counts the last of them. If `hot_i` rises again before then, the count starts over.
- R3: `clk_en_o` is high one clock after any cycle in which `throttle_o` is low or `at_min_i` is low.
- R4: While `throttle_o` and `at_min_i` both stay high, `clk_en_o` follows a repeating pattern of 32 ticks: high for the first 8 and low for the other 24. The pattern starts at the high phase each time modulation begins, and each change of `clk_en_o` is registered.
- R5: While `rst_n` is low, `throttle_o` is 0, `clk_en_o` is 1 and `fwd_valid_o` is 0.
- R6: A request (`req_valid_i` high) with `req_freq_i > opt_freq_i` in a cycle where `throttle_o` is high is not forwarded. It is held instead.
- R7: A request with `req_freq_i <= opt_freq_i`, or any request in a cycle where `throttle_o` is low, appears on the next clock as a one-cycle `fwd_valid_o` pulse, with `fwd_freq_o` equal to the request's frequency.
- R8: At most one request is held. A newer held request replaces the older one, and a request that is forwarded directly throws away any request still held.
- R9: A held request is forwarded as a single `fwd_valid_o` pulse. The pulse comes one clock after the first cycle in which `throttle_o` is low, unless a new request arrives in that same cycle, in which case the new request wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Die temperature above limit |
| at_min_i | input | 1 | Frequency/voltage targets are at their floor |
| tick_i | input | 1 | One-cycle pulse per microsecond from the time base |
| req_valid_i | input | 1 | Performance-state request strobe |
| req_freq_i | input | FREQ_W | Requested frequency code |
| opt_freq_i | input | FREQ_W | Thermally optimized frequency code |
| clk_en_o | output | 1 | Registered core clock enable |
| throttle_o | output | 1 | Throttling active |
| fwd_valid_o | output | 1 | Forwarded request strobe |
| fwd_freq_o | output | FREQ_W | Forwarded frequency code |

## Verification
The properties assume that `hot_i`, `at_min_i` and `tick_i` are synchronous to `clk` and that each tick is a single-cycle pulse. They also assume `opt_freq_i` is stable in any cycle that carries a request. The stimulus drives every input only at the falling edge. It keeps `opt_freq_i` fixed for long stretches and changes it only on cycles with no request. Ticks arrive at a random rate, either every cycle in the directed runs or about one cycle in three in the random run, so the hysteresis and phase counters are exercised at both extremes.

// File: rtl/thermal_clk_modulator.sv
module thermal_clk_modulator #(
  parameter int FREQ_W     = 8,
  parameter int ON_TICKS   = 8,
  parameter int OFF_TICKS  = 24,
  parameter int HYST_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hot_i,
  input  logic              at_min_i,
  input  logic              tick_i,
  input  logic              req_valid_i,
  input  logic [FREQ_W-1:0] req_freq_i,
  input  logic [FREQ_W-1:0] opt_freq_i,
  output logic              clk_en_o,
  output logic              throttle_o,
  output logic              fwd_valid_o,
  output logic [FREQ_W-1:0] fwd_freq_o
);
  localparam int PERIOD = ON_TICKS + OFF_TICKS;
  localparam int PH_W   = $clog2(PERIOD);
  localparam int HC_W   = $clog2(HYST_TICKS + 1);

  logic              active_q;
  logic [HC_W-1:0]   hc_q;
  logic [PH_W-1:0]   ph_q;
  logic              en_q;
  logic              pend_q;
  logic [FREQ_W-1:0] pend_f_q;
  logic              fv_q;
  logic [FREQ_W-1:0] ff_q;

  wire modulating = active_q & at_min_i;
  wire hyst_last  = tick_i & (hc_q == HC_W'(HYST_TICKS - 1));
  wire raise      = req_freq_i > opt_freq_i;
  wire park       = req_valid_i & active_q & raise;

  assign throttle_o  = active_q;
  assign clk_en_o    = en_q;
  assign fwd_valid_o = fv_q;
  assign fwd_freq_o  = ff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hc_q     <= '0;
    end else if (hot_i) begin
      active_q <= 1'b1;
      hc_q     <= '0;
    end else if (active_q && tick_i) begin
      if (hyst_last) begin
        active_q <= 1'b0;
        hc_q     <= '0;
      end else begin
        hc_q <= hc_q + HC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !modulating)
      ph_q <= '0;
    else if (tick_i)
      ph_q <= (ph_q == PH_W'(PERIOD - 1)) ? '0 : ph_q + PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= !modulating || (ph_q < PH_W'(ON_TICKS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_f_q <= '0;
      fv_q     <= 1'b0;
      ff_q     <= '0;
    end else begin
      fv_q <= 1'b0;
      if (park) begin
        pend_q   <= 1'b1;
        pend_f_q <= req_freq_i;
      end else if (req_valid_i) begin
        fv_q   <= 1'b1;
        ff_q   <= req_freq_i;
        pend_q <= 1'b0;
      end else if (!active_q && pend_q) begin
        fv_q   <= 1'b1;
        ff_q   <= pend_f_q;
        pend_q <= 1'b0;
      end
    end
  end

  a_r1_hot_sets_throttle: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> throttle_o);

  a_r2_release_only_when_cool: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(throttle_o) |-> !$past(hot_i));

  a_r3_enable_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!throttle_o || !at_min_i) |=> clk_en_o);

  a_r4_starts_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(throttle_o) && at_min_i) |=> clk_en_o);

  a_r4_gate_needs_throttle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> $past(throttle_o && at_min_i, 2));

  a_r6_raise_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && throttle_o && req_freq_i > opt_freq_i) |=> !fwd_valid_o);

  a_r7_lower_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !(throttle_o && req_freq_i > opt_freq_i))
      |=> (fwd_valid_o && fwd_freq_o == $past(req_freq_i)));

  a_r9_fwd_source: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o |-> ($past(req_valid_i) || !$past(throttle_o)));
endmodule

// File: tb/test_thermal_clk_modulator.sv
`timescale 1ns/1ps
module test_thermal_clk_modulator;
  localparam int FW = 8, ON = 8, OFF = 24, HYST = 16, PER = ON + OFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hot = 1'b0, at_min = 1'b0, tick = 1'b0, rv = 1'b0;
  logic [FW-1:0] rf = '0, opt = '0;
  logic en, thr, fv;
  logic [FW-1:0] ff;

  always #4 clk = ~clk;

  thermal_clk_modulator #(.FREQ_W(FW), .ON_TICKS(ON), .OFF_TICKS(OFF), .HYST_TICKS(HYST))
    i_thermal_clk_modulator (
      .clk(clk), .rst_n(rst_n), .hot_i(hot), .at_min_i(at_min), .tick_i(tick),
      .req_valid_i(rv), .req_freq_i(rf), .opt_freq_i(opt),
      .clk_en_o(en), .throttle_o(thr), .fwd_valid_o(fv), .fwd_freq_o(ff));

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_act = 0, m_en = 1, m_pv = 0, m_fv = 0;
  int m_hc = 0, m_ph = 0, m_pf = 0, m_ff = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic model_step();
    bit n_act = m_act, n_en, n_pv = m_pv, n_fv = 0, mod;
    int n_hc = m_hc, n_ph = m_ph, n_pf = m_pf, n_ff = m_ff;
    if (hot) begin n_act = 1; n_hc = 0; end
    else if (m_act && tick) begin
      if (m_hc == HYST - 1) begin n_act = 0; n_hc = 0; end
      else n_hc = m_hc + 1;
    end
    mod = m_act && at_min;
    if (!mod) n_ph = 0;
    else if (tick) n_ph = (m_ph == PER - 1) ? 0 : m_ph + 1;
    n_en = !mod || (m_ph < ON);
    if (rv) begin
      if (m_act && rf > opt) begin n_pv = 1; n_pf = int'(rf); end
      else begin n_fv = 1; n_ff = int'(rf); n_pv = 0; end
    end else if (!m_act && m_pv) begin
      n_fv = 1; n_ff = m_pf; n_pv = 0;
    end
    m_act = n_act; m_hc = n_hc; m_ph = n_ph; m_en = n_en;
    m_pv = n_pv; m_pf = n_pf; m_fv = n_fv; m_ff = n_ff;
  endtask

  task automatic compare();
    chk(thr == m_act, "R1/R2 throttle_o", int'(thr), int'(m_act));
    chk(en == m_en, "R3/R4 clk_en_o", int'(en), int'(m_en));
    chk(fv == m_fv, "R6/R7/R9 fwd_valid_o", int'(fv), int'(m_fv));
    if (m_fv) chk(int'(ff) == m_ff, "R7/R8/R9 fwd_freq_o", int'(ff), m_ff);
  endtask

  task automatic cyc(bit h, bit a, bit t, bit v, int f);
    hot = h; at_min = a; tick = t; rv = v; rf = FW'(f);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int n, hi;
    bit h, a;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(thr == 0, "R5 reset throttle_o", int'(thr), 0);
    chk(en == 1, "R5 reset clk_en_o", int'(en), 1);
    chk(fv == 0, "R5 reset fwd_valid_o", int'(fv), 0);
    rst_n = 1'b1;
    opt = 8'd100;

    // R4: duty pattern with a tick every cycle
    cyc(1, 1, 1, 0, 0);
    hi = 0;
    for (int k = 1; k <= 128; k++) begin
      cyc(1, 1, 1, 0, 0);
      if (en) hi++;
      if (k == 8) chk(en == 1, "R4 last enabled tick", int'(en), 1);
      if (k == 9) chk(en == 0, "R4 first gated tick", int'(en), 0);
    end
    chk(hi == 4 * ON, "R4 enabled count over four periods", hi, 4 * ON);

    // R2: hysteresis length and restart
    n = 0;
    do begin cyc(0, 1, 1, 0, 0); n++; end while (thr && n < 1000);
    chk(n == HYST, "R2 hysteresis ticks", n, HYST);
    cyc(1, 1, 1, 0, 0);
    repeat (5) cyc(0, 1, 1, 0, 0);
    cyc(1, 1, 1, 0, 0);
    chk(thr == 1, "R2 still throttling after reassert", int'(thr), 1);
    n = 0;
    do begin cyc(0, 1, 1, 0, 0); n++; end while (thr && n < 1000);
    chk(n == HYST, "R2 restarted hysteresis ticks", n, HYST);

    // R3: no gating while targets not at minimum
    hi = 0;
    for (int k = 0; k < 40; k++) begin cyc(1, 0, 1, 0, 0); if (en) hi++; end
    chk(hi == 40, "R3 enable held with at_min low", hi, 40);

    // R6/R7/R8/R9: request routing
    cyc(1, 1, 0, 1, 100);
    chk(fv == 1 && ff == 8'd100, "R7 equal frequency forwarded", int'(ff), 100);
    cyc(1, 1, 0, 1, 40);
    chk(fv == 1 && ff == 8'd40, "R7 lower frequency forwarded", int'(ff), 40);
    cyc(1, 1, 0, 1, 150);
    chk(fv == 0, "R6 raise held", int'(fv), 0);
    cyc(1, 1, 0, 1, 180);
    chk(fv == 0, "R6 second raise held", int'(fv), 0);
    n = 0;
    do begin cyc(0, 1, 1, 0, 0); n++; end while (thr && n < 1000);
    chk(fv == 0, "R9 no pulse while throttle still high", int'(fv), 0);
    cyc(0, 1, 1, 0, 0);
    chk(fv == 1, "R9 held request released", int'(fv), 1);
    chk(ff == 8'd180, "R8 newest held value", int'(ff), 180);
    cyc(0, 1, 1, 0, 0);
    chk(fv == 0, "R9 single release pulse", int'(fv), 0);
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, 0, 1, 200);
    cyc(1, 1, 0, 1, 30);
    chk(fv == 1 && ff == 8'd30, "R8 lower request forwarded", int'(ff), 30);
    n = 0;
    do begin cyc(0, 1, 1, 0, 0); n++; end while (thr && n < 1000);
    hi = 0;
    for (int k = 0; k < 3; k++) begin cyc(0, 1, 1, 0, 0); if (fv) hi++; end
    chk(hi == 0, "R8 discarded held request not released", hi, 0);

    // random run against the model
    h = 0; a = 1;
    for (int k = 0; k < 6000; k++) begin
      bit v;
      if ($urandom % 40 == 0) h = ~h;
      if ($urandom % 25 == 0) a = ~a;
      v = ($urandom % 5 == 0);
      if (!v && k % 500 == 0) opt = FW'($urandom);
      cyc(h, a, ($urandom % 3 == 0), v, int'($urandom % 256));
    end
    summary();
  end
endmodule